// File: doc/BRIEF.md
# Chainable Four-Bit Function ALU

This block is a purely combinational arithmetic logic unit. It is built from four-bit slices. Each slice takes two operand nibbles, a shared three-bit function code and a carry input. It returns a result nibble, a carry output and a signed overflow flag. The top level chains `W/4` slices by feeding each slice's carry output into the carry input of the next higher slice, so the default `W = 8` forms an eight-bit ALU from two slices.

Three codes are arithmetic: two subtractions (A−B and B−A) and one addition. All three take their carry-in from the `cin` port, so a caller can chain wider words or apply a borrow. Four codes are bitwise logic or constants (XOR, OR, AND, all-ones), and one clears the result. The block has no clock and no storage: the outputs follow the inputs within the same cycle. Its data pins are plain combinational values rather than valid/ready streams, because there is nothing to hold or to back-pressure.

Top module: `alu_chain`

## Requirements
- R1: The function code `sel` selects the operation: 3'b000 clear, 3'b001 B minus A, 3'b010 A minus B, 3'b011 A plus B, 3'b100 XOR, 3'b101 OR, 3'b110 AND, 3'b111 preset.
- R2: For code 3'b010, `{cout,f}` equals A + ~B + cin over the full width. With cin=1, `f` is the exact difference A−B; with cin=0 it is one less. For example, A=0x04, B=0x01, cin=1 gives 0x03.
- R3: For code 3'b001, `{cout,f}` equals B + ~A + cin over the full width. With cin=1, `f` is the exact difference B−A.
- R4: For code 3'b011, `{cout,f}` equals A + B + cin, where `cout` is the carry out of the most significant bit.
- R5: Codes 3'b100, 3'b101 and 3'b110 give the bitwise XOR, OR and AND of A and B over the full width, and `cin` has no effect on them. For example, A=0x04 OR B=0x01 gives 0x05.
- R6: Code 3'b000 forces `f` to all zeros and code 3'b111 forces `f` to all ones, whatever A, B and cin are.
- R7: For every non-arithmetic code (000, 100, 101, 110, 111), `cout` and `ovf` are both 0.
- R8: For the arithmetic codes, `ovf` is 1 exactly when the signed two's-complement result of the full-width operation (with its carry-in) falls outside the W-bit signed range.
- R9: Carries ripple across slice boundaries, so the chained result equals a single full-width operation. For example, 0x0F + 0x01 gives 0x10, and 0xFF + 0x01 gives 0x00 with cout=1.
- R10: The block is combinational: a change on any input appears on `f`, `cout` and `ovf` within the same cycle, with no clock or reset involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | Operand A |
| b | input | W | Operand B |
| sel | input | 3 | Function code |
| cin | input | 1 | Carry input to the lowest slice |
| f | output | W | Result |
| cout | output | 1 | Carry output of the highest slice (0 for non-arithmetic codes) |
| ovf | output | 1 | Signed overflow of the full-width arithmetic result |

## Verification
The block holds no state, so a fault inside it shows at the ports in the same cycle as the stimulus that exposes it. A wrong function decode corrupts `f` for every operand pair under that code. A broken carry link between slices only appears when a lower nibble generates or propagates a carry, so the stimulus includes directed operands that cross the nibble boundary and long runs of random operands under every code and both carry-in values. A swapped operand inversion shows up as a difference between the two subtraction codes, and a wrong overflow tap shows up only near the signed limits, which are driven on purpose.

// File: rtl/alu_chain_pkg.sv
package alu_chain_pkg;

  localparam int unsigned SLICE_W = 4;

  typedef enum logic [2:0] {
    FN_CLEAR = 3'b000,
    FN_BSUBA = 3'b001,
    FN_ASUBB = 3'b010,
    FN_ADD   = 3'b011,
    FN_XOR   = 3'b100,
    FN_OR    = 3'b101,
    FN_AND   = 3'b110,
    FN_SET   = 3'b111
  } alu_fn_e;

  typedef enum logic [2:0] {
    LM_ZERO,
    LM_ONES,
    LM_XOR,
    LM_OR,
    LM_AND,
    LM_SUM
  } alu_lmode_e;

  typedef struct packed {
    logic       arith;
    logic       inv_a;
    logic       inv_b;
    alu_lmode_e lmode;
  } alu_ctl_t;

endpackage

// File: rtl/alu_fn_decode.sv
module alu_fn_decode
  import alu_chain_pkg::*;
(
  input  logic [2:0] sel,
  output alu_ctl_t   ctl
);

  always_comb begin
    ctl = '{arith: 1'b0, inv_a: 1'b0, inv_b: 1'b0, lmode: LM_ZERO};
    unique case (alu_fn_e'(sel))
      FN_CLEAR: ctl.lmode = LM_ZERO;
      FN_BSUBA: begin
        ctl.arith = 1'b1;
        ctl.inv_a = 1'b1;
        ctl.lmode = LM_SUM;
      end
      FN_ASUBB: begin
        ctl.arith = 1'b1;
        ctl.inv_b = 1'b1;
        ctl.lmode = LM_SUM;
      end
      FN_ADD: begin
        ctl.arith = 1'b1;
        ctl.lmode = LM_SUM;
      end
      FN_XOR: ctl.lmode = LM_XOR;
      FN_OR:  ctl.lmode = LM_OR;
      FN_AND: ctl.lmode = LM_AND;
      FN_SET: ctl.lmode = LM_ONES;
      default: ctl.lmode = LM_ZERO;
    endcase
  end

endmodule

// File: rtl/alu_result_mux.sv
module alu_result_mux
  import alu_chain_pkg::*;
#(
  parameter int unsigned SW = SLICE_W
) (
  input  alu_lmode_e      lmode,
  input  logic [SW-1:0]   a,
  input  logic [SW-1:0]   b,
  input  logic [SW-1:0]   sum,
  output logic [SW-1:0]   f
);

  always_comb begin
    unique case (lmode)
      LM_ZERO: f = '0;
      LM_ONES: f = '1;
      LM_XOR:  f = a ^ b;
      LM_OR:   f = a | b;
      LM_AND:  f = a & b;
      LM_SUM:  f = sum;
      default: f = '0;
    endcase
  end

endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_chain_pkg::*;
#(
  parameter int unsigned SW = SLICE_W
) (
  input  logic [SW-1:0] a,
  input  logic [SW-1:0] b,
  input  alu_ctl_t      ctl,
  input  logic          cin,
  output logic [SW-1:0] f,
  output logic          cout,
  output logic          ovf
);

  logic [SW-1:0] opx;
  logic [SW-1:0] opy;
  logic [SW:0]   sum;
  logic          sgn_ovf;

  always_comb begin
    opx = ctl.inv_a ? ~a : a;
    opy = ctl.inv_b ? ~b : b;
    sum = {1'b0, opx} + {1'b0, opy} + {{SW{1'b0}}, cin};
    sgn_ovf = (opx[SW-1] == opy[SW-1]) && (sum[SW-1] != opx[SW-1]);
  end

  alu_result_mux #(.SW(SW)) u_mux (
    .lmode (ctl.lmode),
    .a     (a),
    .b     (b),
    .sum   (sum[SW-1:0]),
    .f     (f)
  );

  assign cout = ctl.arith & sum[SW];
  assign ovf  = ctl.arith & sgn_ovf;

endmodule

// File: rtl/alu_chain.sv
module alu_chain
  import alu_chain_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   sel,
  input  logic         cin,
  output logic [W-1:0] f,
  output logic         cout,
  output logic         ovf
);

  localparam int unsigned NSL = W / SLICE_W;
  localparam logic [NSL-1:0] TOP_SEL = NSL'(1) << (NSL - 1);

  alu_ctl_t       ctl;
  logic [NSL:0]   carry;
  logic [NSL-1:0] ovf_sl;

  alu_fn_decode u_dec (
    .sel (sel),
    .ctl (ctl)
  );

  assign carry[0] = cin;

  for (genvar gi = 0; gi < NSL; gi++) begin : g_slice
    alu_slice #(.SW(SLICE_W)) u_slice (
      .a    (a[gi*SLICE_W +: SLICE_W]),
      .b    (b[gi*SLICE_W +: SLICE_W]),
      .ctl  (ctl),
      .cin  (carry[gi]),
      .f    (f[gi*SLICE_W +: SLICE_W]),
      .cout (carry[gi+1]),
      .ovf  (ovf_sl[gi])
    );
  end

  assign cout = carry[NSL];
  assign ovf  = |(ovf_sl & TOP_SEL);

endmodule

// File: rtl/alu_chain_chk.sv
module alu_chain_chk #(
  parameter int unsigned W = 8
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [2:0]   sel,
  input logic         cin,
  input logic [W-1:0] f,
  input logic         cout,
  input logic         ovf
);

  logic [W:0] full_add;
  logic [W:0] full_asubb;
  logic [W:0] full_bsuba;

  always_comb begin
    full_add   = {1'b0, a} + {1'b0, b} + (W+1)'(cin);
    full_asubb = {1'b0, a} + {1'b0, ~b} + (W+1)'(cin);
    full_bsuba = {1'b0, b} + {1'b0, ~a} + (W+1)'(cin);
  end

  always_comb begin
    // R6
    clear_zero_chk: assert (sel != 3'b000 || f == '0);
    // R6
    preset_ones_chk: assert (sel != 3'b111 || f == '1);
    // R7
    no_flags_logic_chk: assert (sel == 3'b001 || sel == 3'b010 || sel == 3'b011 || (!cout && !ovf));
    // R5
    or_bits_chk: assert (sel != 3'b101 || f == (a | b));
    // R4 R9
    add_chain_chk: assert (sel != 3'b011 || {cout, f} == full_add);
    // R2 R9
    asubb_chain_chk: assert (sel != 3'b010 || {cout, f} == full_asubb);
    // R3 R9
    bsuba_chain_chk: assert (sel != 3'b001 || {cout, f} == full_bsuba);
  end

endmodule

bind alu_chain alu_chain_chk #(.W(W)) u_alu_chain_chk (
  .a    (a),
  .b    (b),
  .sel  (sel),
  .cin  (cin),
  .f    (f),
  .cout (cout),
  .ovf  (ovf)
);

// File: tb/test_alu_chain.sv
module test_alu_chain;

  localparam int W = 8;
  localparam int MASK = (1 << W) - 1;
  localparam int SMAX = (1 << (W - 1)) - 1;
  localparam int SMIN = -(1 << (W - 1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic [2:0]   sel = 3'b000;
  logic         cin = 1'b0;
  logic [W-1:0] f;
  logic         cout;
  logic         ovf;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  alu_chain #(.W(W)) i_alu_chain (
    .a(a), .b(b), .sel(sel), .cin(cin), .f(f), .cout(cout), .ovf(ovf)
  );

  function automatic int sx(input int v);
    return (v > SMAX) ? v - (1 << W) : v;
  endfunction

  task automatic model(input int av, input int bv, input int s, input int c,
                       output int ef, output int ec, output int eo);
    int raw;
    int sres;
    ef = 0; ec = 0; eo = 0;
    case (s)
      0: ef = 0;
      1: begin
        raw = bv + ((~av) & MASK) + c;
        sres = sx(bv) - sx(av) - 1 + c;
        ef = raw & MASK; ec = (raw >> W) & 1;
        eo = (sres > SMAX || sres < SMIN) ? 1 : 0;
      end
      2: begin
        raw = av + ((~bv) & MASK) + c;
        sres = sx(av) - sx(bv) - 1 + c;
        ef = raw & MASK; ec = (raw >> W) & 1;
        eo = (sres > SMAX || sres < SMIN) ? 1 : 0;
      end
      3: begin
        raw = av + bv + c;
        sres = sx(av) + sx(bv) + c;
        ef = raw & MASK; ec = (raw >> W) & 1;
        eo = (sres > SMAX || sres < SMIN) ? 1 : 0;
      end
      4: ef = av ^ bv;
      5: ef = av | bv;
      6: ef = av & bv;
      default: ef = MASK;
    endcase
  endtask

  task automatic apply_check(input int av, input int bv, input int s, input int c,
                             input string req);
    int ef, ec, eo;
    @(posedge clk);
    a = W'(av); b = W'(bv); sel = 3'(s); cin = c[0];
    model(av, bv, s, c, ef, ec, eo);
    @(negedge clk);
    checks++;
    if (int'(f) != ef || int'(cout) != ec || int'(ovf) != eo) begin
      errors++;
      $display("FAIL %s sel=%0d a=%02h b=%02h cin=%0d: got f=%02h cout=%0d ovf=%0d, expected f=%02h cout=%0d ovf=%0d",
               req, s, av, bv, c, f, cout, ovf, ef, ec, eo);
    end
  endtask

  initial begin
    int wd = 0;
    while (!done) begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, got %0d cycles expected under 150000", wd);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int seed = 7;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R10 R6: idle state with all inputs zero gives a cleared result
    apply_check(0, 0, 0, 0, "R10");
    // R2: stated subtract example
    apply_check(8'h04, 8'h01, 2, 1, "R2");
    apply_check(8'h04, 8'h01, 2, 0, "R2");
    // R3: reverse subtract
    apply_check(8'h04, 8'h01, 1, 1, "R3");
    apply_check(8'h01, 8'h04, 1, 1, "R3");
    // R5: stated OR example, cin has no effect
    apply_check(8'h04, 8'h01, 5, 0, "R5");
    apply_check(8'h04, 8'h01, 5, 1, "R5");
    apply_check(8'hA5, 8'h3C, 4, 1, "R5");
    apply_check(8'hA5, 8'h3C, 6, 1, "R5");
    // R6 R7: constants ignore operands and carry
    apply_check(8'hFF, 8'hFF, 0, 1, "R6");
    apply_check(8'h00, 8'h00, 7, 1, "R6");
    apply_check(8'hFF, 8'h01, 6, 1, "R7");
    // R9 R4: carry crosses the slice boundary
    apply_check(8'h0F, 8'h01, 3, 0, "R9");
    apply_check(8'hFF, 8'h01, 3, 0, "R9");
    apply_check(8'h0F, 8'h00, 3, 1, "R4");
    // R8: signed limits
    apply_check(8'h7F, 8'h01, 3, 0, "R8");
    apply_check(8'h80, 8'hFF, 3, 0, "R8");
    apply_check(8'h80, 8'h01, 2, 1, "R8");
    apply_check(8'h7F, 8'hFF, 2, 1, "R8");
    apply_check(8'h80, 8'h00, 1, 1, "R8");
    apply_check(8'h7F, 8'h00, 3, 1, "R8");
    // R1: every code with random operands and both carry values
    for (int s = 0; s < 8; s++) begin
      for (int n = 0; n < 1500; n++) begin
        int av = $urandom(seed) & MASK;
        int bv = $urandom & MASK;
        apply_check(av, bv, s, n & 1, "R1");
        seed = 0;
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule